// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a one-bit serial stream, clocked by the serial bit clock, into parallel words of a parameterised width (eight bits by default). Every rising edge of the bit clock shifts one data bit into a shift register. A small divider counter marks the last bit of each word, and the shift register contents are then copied into a holding register that drives the word output. The same counter produces a parallel word clock at one eighth of the bit rate, and a one-cycle word-valid strobe marks each update.

Framing logic downstream searches for frame alignment by asking the block to move the word boundary by one bit. It does this by raising a slip request input. The request first passes through a two-flop synchronizer and must then be seen high on at least two consecutive bit clocks. An accepted request freezes the divider for one bit time, during a low phase of the word clock. That one word period lasts nine bit times, its oldest bit never reaches the output, and every later word starts one bit further along the stream. A single request produces one slip however long it stays high. The request must go low before another slip can be made.

Top module: `bitslip_deser`

## Requirements
- R1: A synchronous active-high reset clears the word output, the word-valid strobe and the word clock to 0 and restarts the divider. The first word after reset is made of the bits sampled on bit-clock edges 1 to 8 after reset is released, and it appears on edge 8.
- R2: On each update, `parData` holds the last eight sampled bits. The earliest of them is on bit 7 and the latest, sampled on the update edge itself, is on bit 0.
- R3: Without an accepted slip request, the word updates every 8 bit-clock cycles. `wordValid` is high for exactly the one cycle following each update edge.
- R4: `parClk` is high for 4 cycles and low for 4 cycles. `parData` changes only on the edge where `parClk` falls, and that edge is also the one that raises `wordValid`.
- R5: A request that is seen high on only one bit-clock edge at a time is ignored. No word period is stretched.
- R6: An accepted request held high for 2 or more edges lengthens exactly one word period, and that period's `parClk` low phase, to 9 cycles. The oldest of those 9 bits is dropped from the output.
- R7: If the request is first sampled high on edge r, the stretched word is delivered on an edge from r+12 to r+19. This means the frozen bit time falls within two word periods of the request.
- R8: One request gives at most one slip, however long it stays high. A second slip needs the request to go low and then be accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial data bit |
| syncIn | input | 1 | Asynchronous bit-slip request, active high |
| parData | output | 8 | Deserialized word, earliest bit on the MSB |
| parClk | output | 1 | Divided word clock; data changes on its falling edge |
| wordValid | output | 1 | One-cycle strobe after each word update |

## Verification
The bench drives a seeded bit pattern and checks every delivered word against the last eight bits it sent. A shift in the wrong direction, an off-by-one capture edge or a wrong reset count therefore shows up as a data mismatch or as a first word on the wrong edge. Slip requests are placed at several word phases and held for exactly two edges, for longer, and for a very long time. A qualifier that counts the wrong number of edges would slip on single-edge pulses or miss two-edge ones. A missing one-shot guard would slip repeatedly during the long hold. A slip placed too late or frozen in the high phase would break the 12-to-19 edge window or the 4-high/5-low word clock shape.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capture;   // last bit of a word is being sampled this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        syncIn,
  output ctrlStrobe_t strobe,
  output logic        parClk
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int RUN_W = $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   syncLvl;
  logic [RUN_W-1:0]       highRun;
  logic                   qualify;
  logic                   pendingQ;
  logic                   stall;
  logic [CNT_W-1:0]       cnt, cntNext;
  logic                   capture;
  logic                   parClkQ;

  // synchronizer for the request
  always_ff @(posedge clk) begin
    if (rst) syncPipe <= '0;
    else     syncPipe <= {syncPipe[SYNC_STAGES-2:0], syncIn};
  end
  assign syncLvl = syncPipe[SYNC_STAGES-1];

  // run length of the synchronized request, saturating
  always_ff @(posedge clk) begin
    if (rst || !syncLvl)                  highRun <= '0;
    else if (highRun != RUN_W'(MIN_HIGH)) highRun <= highRun + 1'b1;
  end

  // fires exactly once per high run that is long enough
  assign qualify = syncLvl && (highRun == RUN_W'(MIN_HIGH - 1));

  // the slip waits for the start of a low phase
  assign stall = pendingQ && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) pendingQ <= 1'b0;
    else     pendingQ <= (pendingQ && !stall) || qualify;
  end

  // divider
  assign capture = (cnt == LAST);
  always_comb begin
    if (stall)        cntNext = cnt;
    else if (capture) cntNext = '0;
    else              cntNext = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      parClkQ <= 1'b0;
    end else begin
      cnt     <= cntNext;
      parClkQ <= (cntNext >= HALF);
    end
  end

  assign strobe.capture = capture;
  assign parClk         = parClkQ;

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    qualify |=> !qualify);

  // R6
  one_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R6
  stall_low_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !parClkQ);

  // R4
  fall_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(parClkQ) && !$past(rst)) |-> $past(capture));
endmodule

// File: rtl/deser_dp.sv
module deser_dp
  import deser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  ctrlStrobe_t       strobe,
  output logic [WORD_W-1:0] parData,
  output logic              wordValid
);
  logic [WORD_W-1:0] shReg, shNext, outReg;
  logic              validQ;

  // earliest bit ends up in the MSB
  assign shNext = {shReg[WORD_W-2:0], serIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg  <= '0;
      outReg <= '0;
      validQ <= 1'b0;
    end else begin
      shReg  <= shNext;
      validQ <= strobe.capture;
      if (strobe.capture) outReg <= shNext;
    end
  end

  assign parData   = outReg;
  assign wordValid = validQ;

  // R2
  latest_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (wordValid && !$past(rst)) |-> (parData[0] == $past(serIn)));

  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!wordValid && !$past(rst)) |-> $stable(parData));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import deser_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  logic              syncIn,
  output logic [WORD_W-1:0] parData,
  output logic              parClk,
  output logic              wordValid
);
  ctrlStrobe_t strobe;

  deser_ctrl #(
    .WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES), .MIN_HIGH(MIN_HIGH)
  ) ctrl_i (
    .clk(clk), .rst(rst), .syncIn(syncIn), .strobe(strobe), .parClk(parClk)
  );

  deser_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst(rst), .serIn(serIn), .strobe(strobe),
    .parData(parData), .wordValid(wordValid)
  );

  // R4
  valid_with_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> !parClk);
endmodule

// File: tb/bitslip_deser_tb.sv
module bitslip_deser_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serIn = 1'b0;
  logic       syncIn = 1'b0;
  logic [7:0] parData;
  logic       parClk;
  logic       wordValid;

  int compared = 0, mismatched = 0;
  int edgeN = 0, seed = 1;
  int lastCap = 0, firstCap = 0, slipCnt = 0, lastSlipCap = 0, lowFive = 0;
  logic prevPc = 1'b0, pcTrack = 1'b0;
  int runLen = 0;
  logic [7:0] prevData = '0;

  bitslip_deser dut_i (
    .clk(clk), .rst(rst), .serIn(serIn), .syncIn(syncIn),
    .parData(parData), .parClk(parClk), .wordValid(wordValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic stimBit(int n);
    logic [31:0] v;
    v = 32'(n * seed) ^ 32'((n >> 2) * 13);
    return ^v[9:0];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) edgeN = 0;
    else     edgeN = edgeN + 1;
  end

  // serial driver: bit for the coming edge
  always @(negedge clk) serIn = stimBit(edgeN + 1);

  // output monitor
  always @(negedge clk) begin
    if (rst) begin
      lastCap = 0; firstCap = 0; pcTrack = 1'b0; prevPc = 1'b0;
      runLen = 0; prevData = '0;
    end else begin
      if (wordValid) begin
        logic [7:0] expW;
        for (int k = 0; k < 8; k++) expW[7-k] = stimBit(edgeN - 7 + k);
        chk(parData == expW, "R2", "word content", parData, expW);
        chk(!parClk && prevPc, "R4", "update at clock fall", {parClk, prevPc}, 1);
        if (firstCap == 0) firstCap = edgeN;
        if (lastCap != 0) begin
          if (edgeN - lastCap == 9) begin
            slipCnt++;
            lastSlipCap = edgeN;
          end else
            chk(edgeN - lastCap == 8, "R3", "word spacing", edgeN - lastCap, 8);
        end
        lastCap = edgeN;
      end else begin
        chk(parData == prevData, "R4", "data stable between updates", parData, prevData);
      end
      prevData = parData;
      if (parClk == prevPc) runLen++;
      else begin
        if (pcTrack) begin
          if (prevPc) chk(runLen == 4, "R4", "high phase length", runLen, 4);
          else if (runLen == 5) lowFive++;
          else chk(runLen == 4, "R4", "low phase length", runLen, 4);
        end
        if (prevPc && !parClk) pcTrack = 1'b1;
        runLen = 1;
      end
      prevPc = parClk;
    end
  end

  task automatic doReset(int s);
    @(negedge clk);
    rst = 1'b1; syncIn = 1'b0; seed = s;
    repeat (3) @(negedge clk);
    chk(parData == 8'h00, "R1", "data in reset", parData, 0);
    chk(wordValid == 1'b0, "R1", "valid in reset", wordValid, 0);
    chk(parClk == 1'b0, "R1", "word clock in reset", parClk, 0);
    rst = 1'b0;
  endtask

  task automatic testResetStart();
    doReset(5);
    repeat (20) @(negedge clk);
    chk(firstCap == 8, "R1", "first word edge", firstCap, 8);
  endtask

  task automatic testNormal(int s);
    int base;
    doReset(s);
    base = slipCnt;
    repeat (80) @(negedge clk);
    chk(slipCnt == base, "R3", "no stretched period", slipCnt - base, 0);
  endtask

  task automatic testShortSync();
    int base, baseLow;
    doReset(9);
    base = slipCnt; baseLow = lowFive;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      syncIn = 1'b1;
      @(negedge clk);
      syncIn = 1'b0;
      repeat (13 + i) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    chk(slipCnt == base, "R5", "slips from short pulses", slipCnt - base, 0);
    chk(lowFive == baseLow, "R5", "long low phases", lowFive - baseLow, 0);
  endtask

  task automatic testSlip(int s, int offset, int hold);
    int base, baseLow, r;
    doReset(s);
    base = slipCnt; baseLow = lowFive;
    repeat (offset) @(negedge clk);
    syncIn = 1'b1;
    r = edgeN + 1;
    repeat (hold) @(negedge clk);
    syncIn = 1'b0;
    repeat (40) @(negedge clk);
    chk(slipCnt - base == 1, "R6", "one stretched period", slipCnt - base, 1);
    chk(lowFive - baseLow == 1, "R6", "one 5-cycle low phase", lowFive - baseLow, 1);
    chk(lastSlipCap >= r + 12 && lastSlipCap <= r + 19, "R7",
        "stretched word edge minus request edge", lastSlipCap - r, 12);
  endtask

  task automatic testLongSync();
    int base;
    doReset(21);
    base = slipCnt;
    repeat (7) @(negedge clk);
    syncIn = 1'b1;
    repeat (60) @(negedge clk);
    chk(slipCnt - base == 1, "R8", "slips during long hold", slipCnt - base, 1);
    syncIn = 1'b0;
    repeat (6) @(negedge clk);
    syncIn = 1'b1;
    repeat (2) @(negedge clk);
    syncIn = 1'b0;
    repeat (40) @(negedge clk);
    chk(slipCnt - base == 2, "R8", "slip after re-request", slipCnt - base, 2);
  endtask

  initial begin
    testResetStart();
    testNormal(3);
    testNormal(77);
    testShortSync();
    testSlip(11, 5, 2);
    testSlip(29, 9, 3);
    testSlip(45, 14, 6);
    testLongSync();
    testNormal(101);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule